// File: doc/BRIEF.md
# Voltmeter Scaling and Serial Display Driver

This block runs the display path of a two-digit voltmeter reading 0 to 5 V. Each time a periodic trigger arrives, it asks an external analog converter for one sample and waits for the converter to report completion. It then scales the 10-bit code to a whole number of tenths of a volt and splits that number into a tens digit and a units digit. Each digit is turned into a seven-segment pattern.

The two pattern bytes are shifted out as an SPI master in mode 0. The receiver is a chain of two serial-in, parallel-out registers, and each register has its own output holding stage. A separate latch line frames the whole transfer. Because the holding stages only update when the latch rises, the visible digits never show a partly shifted value.

In the target system the trigger arrives about every 262 ms (16 x 2^16 cycles of a 4 MHz oscillator). A whole sequence takes far less time than that. The SCK half-period is a parameter. With a 2 MHz clock and a half-period of 24 cycles, the serial clock is 2 MHz / 48. Any setting must keep the serial clock below 21 MHz.

Top module: `vmeter_disp_top`

## Requirements
- R1: A trigger seen while the block is idle produces `conv_start_o` high for exactly one cycle, in the cycle after the trigger. The latch line is high whenever the start pulse is high.
- R2: The result is taken from `conv_data_i` only in the cycle where `conv_done_i` is high. Values on `conv_data_i` in any other cycle have no effect on the displayed digits.
- R3: The scaled value is floor((R*50 + 25) / 1024), where R is the captured 10-bit code.
- R4: The tens digit is the scaled value divided by 10, and the units digit is the remainder.
- R5: Segment bytes are active high. Bit 0 = A (top), bit 1 = B (upper right), bit 2 = C (lower right), bit 3 = D (bottom), bit 4 = E (lower left), bit 5 = F (upper left), bit 6 = G (middle), and bit 7 is always 0. The digits 0..9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R6: The latch falls before the first SCK rise of a frame. It rises again only after exactly 16 SCK rises. SCK stays low whenever the latch is high.
- R7: Bits go out most significant first, and the tens byte is sent before the units byte. After the latch rises, the upper byte of the 16-bit receiver chain holds the tens pattern and the lower byte holds the units pattern.
- R8: SCK idles low. Within a byte, each bit lasts 2*SCK_HALF cycles: SCK is low for the first half and high for the second half. MOSI changes only while SCK is low.
- R9: A trigger that arrives while a sequence is in progress is ignored, and no extra conversion start follows from it.
- R10: During reset, the latch line is high and SCK, MOSI and `conv_start_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Periodic request for one display update |
| conv_start_o | output | 1 | One-cycle request to the converter |
| conv_done_i | input | 1 | Converter reports that its result is valid |
| conv_data_i | input | RES_W | Converter result |
| sck_o | output | 1 | Serial clock to the register chain |
| mosi_o | output | 1 | Serial data to the register chain |
| latch_o | output | 1 | Holding-register strobe, low while shifting |

## Verification
The assertions assume a converter that raises `conv_done_i` only after it has been asked, and that holds it for one cycle while the result is valid. The bench converter model follows this: it waits for the start pulse, delays a few cycles, and then presents the true code for a single done cycle. Outside that cycle it drives the inverted code, so a capture made at the wrong time would show up as wrong digits. The sweep applies every 10-bit code once. Extra trigger pulses are placed only while a frame is being shifted, which is where the ignore rule applies.

// File: rtl/vm_pkg.sv
package vm_pkg;
  localparam int BYTE_W  = 8;
  localparam int DIGIT_W = 4;
  localparam int N_DIGIT = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PREP,
    ST_SEND_HI,
    ST_SEND_LO
  } vm_state_e;
endpackage

// File: rtl/vm_scale_split.sv
module vm_scale_split #(
  parameter int RES_W     = 10,
  parameter int SCALE_NUM = 50
) (
  input  logic [RES_W-1:0]            sample_i,
  output logic [vm_pkg::DIGIT_W-1:0]  tens_o,
  output logic [vm_pkg::DIGIT_W-1:0]  units_o
);
  localparam int VAL_W  = $clog2(SCALE_NUM + 1);
  localparam int PROD_W = RES_W + VAL_W + 1;

  logic [PROD_W-1:0] prod;
  logic [VAL_W-1:0]  value;

  always_comb begin
    prod    = PROD_W'(sample_i) * PROD_W'(SCALE_NUM) + PROD_W'(SCALE_NUM / 2);
    value   = VAL_W'(prod >> RES_W);
    tens_o  = vm_pkg::DIGIT_W'(value / VAL_W'(10));
    units_o = vm_pkg::DIGIT_W'(value % VAL_W'(10));
  end
endmodule

// File: rtl/vm_seg7.sv
module vm_seg7 (
  input  logic [vm_pkg::DIGIT_W-1:0] digit_i,
  output logic [vm_pkg::BYTE_W-1:0]  pattern_o
);
  // bit order: {unused, G, F, E, D, C, B, A}
  always_comb begin
    case (digit_i)
      4'd0:    pattern_o = 8'h3F;
      4'd1:    pattern_o = 8'h06;
      4'd2:    pattern_o = 8'h5B;
      4'd3:    pattern_o = 8'h4F;
      4'd4:    pattern_o = 8'h66;
      4'd5:    pattern_o = 8'h6D;
      4'd6:    pattern_o = 8'h7D;
      4'd7:    pattern_o = 8'h07;
      4'd8:    pattern_o = 8'h7F;
      4'd9:    pattern_o = 8'h6F;
      default: pattern_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/vm_spi_byte.sv
module vm_spi_byte #(
  parameter int BYTE_W   = 8,
  parameter int SCK_HALF = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              done_o,
  output logic              sck_o,
  output logic              mosi_o
);
  localparam int DIV_W = $clog2(SCK_HALF + 1);
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  logic              act_q, act_nxt;
  logic              ph_q, ph_nxt;
  logic [DIV_W-1:0]  div_q, div_nxt;
  logic [IDX_W-1:0]  idx_q, idx_nxt;
  logic [BYTE_W-1:0] sh_q, sh_nxt;
  logic              done_q, done_nxt;
  logic              tick;

  assign tick = (div_q == DIV_W'(SCK_HALF - 1));

  always_comb begin
    act_nxt  = act_q;
    ph_nxt   = ph_q;
    div_nxt  = div_q;
    idx_nxt  = idx_q;
    sh_nxt   = sh_q;
    done_nxt = 1'b0;
    if (!act_q) begin
      if (start_i) begin
        act_nxt = 1'b1;
        sh_nxt  = data_i;
        div_nxt = '0;
        ph_nxt  = 1'b0;
        idx_nxt = '0;
      end
    end else if (tick) begin
      div_nxt = '0;
      if (!ph_q) begin
        ph_nxt = 1'b1;
      end else begin
        ph_nxt = 1'b0;
        sh_nxt = sh_q << 1;
        if (idx_q == IDX_W'(BYTE_W - 1)) begin
          act_nxt  = 1'b0;
          done_nxt = 1'b1;
        end else begin
          idx_nxt = idx_q + 1'b1;
        end
      end
    end else begin
      div_nxt = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ph_q   <= 1'b0;
      div_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_nxt;
      ph_q   <= ph_nxt;
      div_q  <= div_nxt;
      idx_q  <= idx_nxt;
      sh_q   <= sh_nxt;
      done_q <= done_nxt;
    end
  end

  assign done_o = done_q;
  assign sck_o  = ph_q;
  assign mosi_o = sh_q[BYTE_W-1];
endmodule

// File: rtl/vmeter_disp_top.sv
module vmeter_disp_top #(
  parameter int RES_W     = 10,
  parameter int SCALE_NUM = 50,
  parameter int SCK_HALF  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  output logic             conv_start_o,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             latch_o
);
  import vm_pkg::*;

  vm_state_e        st_q, st_nxt;
  logic [RES_W-1:0] sample_q;
  logic             sample_en;
  logic [BYTE_W-1:0] byte_q   [N_DIGIT];
  logic              byte_en;
  logic              cstart_q, cstart_nxt;
  logic              latch_q, latch_nxt;
  logic              go_q, go_nxt;
  logic [DIGIT_W-1:0] dig [N_DIGIT];
  logic [BYTE_W-1:0]  pat [N_DIGIT];
  logic [BYTE_W-1:0]  tx_data;
  logic               tx_done;

  vm_scale_split #(.RES_W(RES_W), .SCALE_NUM(SCALE_NUM)) u_scale (
    .sample_i (sample_q),
    .tens_o   (dig[1]),
    .units_o  (dig[0])
  );

  for (genvar g = 0; g < N_DIGIT; g++) begin : g_seg
    vm_seg7 u_seg (
      .digit_i   (dig[g]),
      .pattern_o (pat[g])
    );
  end

  assign tx_data = (st_q == ST_SEND_HI) ? byte_q[1] : byte_q[0];

  vm_spi_byte #(.BYTE_W(BYTE_W), .SCK_HALF(SCK_HALF)) u_spi (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (go_q),
    .data_i  (tx_data),
    .done_o  (tx_done),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o)
  );

  always_comb begin
    st_nxt     = st_q;
    cstart_nxt = 1'b0;
    latch_nxt  = latch_q;
    go_nxt     = 1'b0;
    sample_en  = 1'b0;
    byte_en    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (trig_i) begin
          cstart_nxt = 1'b1;
          st_nxt     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (conv_done_i) begin
          sample_en = 1'b1;
          st_nxt    = ST_PREP;
        end
      end
      ST_PREP: begin
        byte_en   = 1'b1;
        latch_nxt = 1'b0;
        go_nxt    = 1'b1;
        st_nxt    = ST_SEND_HI;
      end
      ST_SEND_HI: begin
        if (tx_done) begin
          go_nxt = 1'b1;
          st_nxt = ST_SEND_LO;
        end
      end
      ST_SEND_LO: begin
        if (tx_done) begin
          latch_nxt = 1'b1;
          st_nxt    = ST_IDLE;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cstart_q <= 1'b0;
      latch_q  <= 1'b1;
      go_q     <= 1'b0;
    end else begin
      st_q     <= st_nxt;
      cstart_q <= cstart_nxt;
      latch_q  <= latch_nxt;
      go_q     <= go_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
    end else if (sample_en) begin
      sample_q <= conv_data_i;
    end
  end

  for (genvar b = 0; b < N_DIGIT; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q[b] <= '0;
      end else if (byte_en) begin
        byte_q[b] <= pat[b];
      end
    end
  end

  assign conv_start_o = cstart_q;
  assign latch_o      = latch_q;
endmodule

// File: rtl/vmeter_disp_chk.sv
module vmeter_disp_chk #(
  parameter int FRAME_BITS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic conv_start_o,
  input logic sck_o,
  input logic mosi_o,
  input logic latch_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1) + 1;

  logic             prev_sck_q;
  logic             prev_latch_q;
  logic [CNT_W-1:0] rise_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sck_q   <= 1'b0;
      prev_latch_q <= 1'b1;
      rise_cnt_q   <= '0;
    end else begin
      prev_sck_q   <= sck_o;
      prev_latch_q <= latch_o;
      if (!latch_o && prev_latch_q) begin
        rise_cnt_q <= '0;
      end else if (sck_o && !prev_sck_q) begin
        rise_cnt_q <= rise_cnt_q + 1'b1;
      end
    end
  end

  assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

  assert_start_latch_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> latch_o);

  assert_latch_low_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && !prev_sck_q) |-> !latch_o);

  assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> !sck_o);

  assert_frame_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_o && !prev_latch_q) |-> (rise_cnt_q == CNT_W'(FRAME_BITS)));

  assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && prev_sck_q) |-> $stable(mosi_o));
endmodule

bind vmeter_disp_top vmeter_disp_chk #(.FRAME_BITS(2 * vm_pkg::BYTE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .conv_start_o (conv_start_o),
  .sck_o        (sck_o),
  .mosi_o       (mosi_o),
  .latch_o      (latch_o)
);

// File: tb/vmeter_disp_top_tb_top.sv
module vmeter_disp_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W      = 10;
  localparam int HALF       = 2;
  localparam int WD_CYCLES  = 190000;

  logic             clk;
  logic             rst_n;
  logic             trig_i;
  logic             conv_start_o;
  logic             conv_done_i;
  logic [RES_W-1:0] conv_data_i;
  logic             sck_o;
  logic             mosi_o;
  logic             latch_o;

  int errors = 0;
  int checks = 0;
  int starts = 0;
  int cyc    = 0;
  bit ended  = 0;

  logic [15:0] rx_sr   = '0;
  logic [15:0] rx_hold = '0;
  int          rise_idx = 0;
  realtime     t_r1, t_r2;

  vmeter_disp_top #(.RES_W(RES_W), .SCALE_NUM(50), .SCK_HALF(HALF)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .conv_start_o (conv_start_o),
    .conv_done_i  (conv_done_i),
    .conv_data_i  (conv_data_i),
    .sck_o        (sck_o),
    .mosi_o       (mosi_o),
    .latch_o      (latch_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n && conv_start_o) starts = starts + 1;
  end

  // model of the two chained receiving registers
  always @(posedge sck_o) begin
    rx_sr    = {rx_sr[14:0], mosi_o};
    rise_idx = rise_idx + 1;
    if (rise_idx == 1) t_r1 = $realtime;
    if (rise_idx == 2) t_r2 = $realtime;
  end
  always @(negedge latch_o) rise_idx = 0;
  always @(posedge latch_o) rx_hold = rx_sr;

  function automatic logic [7:0] seg_of(input int d);
    case (d)
      0: return 8'h3F; 1: return 8'h06; 2: return 8'h5B; 3: return 8'h4F;
      4: return 8'h66; 5: return 8'h6D; 6: return 8'h7D; 7: return 8'h07;
      8: return 8'h7F; 9: return 8'h6F;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wait_level(input bit lvl, output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (latch_o == lvl) begin
        ok = 1;
        break;
      end
    end
  endtask

  task automatic run_one(input int r, input bit extra_trig);
    int  s0, v, t, u, exp_word, gap;
    bit  ok, seen;
    s0 = starts;
    @(negedge clk);
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    // R1: start pulse one cycle after trigger
    check(conv_start_o == 1'b1, "R1", conv_start_o, 1);
    seen = conv_start_o;
    for (int i = 0; i < 3; i++) @(negedge clk);
    conv_done_i = 1'b1;
    conv_data_i = RES_W'(r);
    @(negedge clk);
    conv_done_i = 1'b0;
    conv_data_i = ~RES_W'(r);
    wait_level(1'b0, ok);
    check(ok, "R6", ok, 1);
    if (extra_trig) begin
      for (int i = 0; i < 3; i++) @(negedge clk);
      trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
    end
    wait_level(1'b1, ok);
    check(ok, "R6", ok, 1);
    for (int i = 0; i < 6; i++) @(negedge clk);
    v = (r * 50 + 25) / 1024;
    t = v / 10;
    u = v % 10;
    exp_word = {seg_of(t), seg_of(u)};
    // R2 R3 R4 R5 R7: received word after latch
    check(rx_hold == 16'(exp_word), "R3/R4/R5/R7 word", rx_hold, exp_word);
    if (extra_trig) begin
      check(starts == s0 + 1, "R9", starts - s0, 1);
      gap = int'((t_r2 - t_r1) / CLK_PERIOD);
      check(gap == 2 * HALF, "R8", gap, 2 * HALF);
    end
    if (!seen) begin
      for (int i = 0; i < 20; i++) @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < WD_CYCLES; i++) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
    finish_run();
  end

  initial begin
    rst_n       = 1'b0;
    trig_i      = 1'b0;
    conv_done_i = 1'b0;
    conv_data_i = '0;
    repeat (3) @(negedge clk);
    // R10: reset values
    check(latch_o == 1'b1, "R10 latch", latch_o, 1);
    check(sck_o == 1'b0, "R10 sck", sck_o, 0);
    check(mosi_o == 1'b0, "R10 mosi", mosi_o, 0);
    check(conv_start_o == 1'b0, "R10 start", conv_start_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2: data toggling while idle without done has no effect, no start
    conv_data_i = 10'h155;
    repeat (4) @(negedge clk);
    check(starts == 0 && latch_o == 1'b1, "R2 idle", starts, 0);
    // boundary codes first, then full sweep
    run_one(0, 1'b1);
    run_one(1023, 1'b1);
    run_one(20, 1'b0);
    run_one(21, 1'b0);
    for (int r = 0; r < 1024; r++) begin
      run_one(r, (r % 64) == 5);
    end
    finish_run();
  end
endmodule